// File: doc/BRIEF.md
# Performance Limit Sticky Status Register

This block watches four unsigned performance levels every clock: the level actually delivered, the level requested, the minimum acceptable level and the level the platform guarantees. While a limiting-event qualifier is asserted, it compares the delivered level against two thresholds. It records each shortfall in a sticky status bit that stays set until software clears it.

The requested-level threshold is capped at the guaranteed level whenever the request exceeds the guarantee. That comparison is suppressed entirely while autonomous level selection is enabled. Software reads the two-bit status through a small register port and clears bits by writing ones. A hardware set in the same cycle as a clear always survives.

A single-cycle notify pulse goes to the host when the minimum-shortfall bit newly becomes set. Sustained or recurring limiting while that bit remains set raises no further notify.

Top module: `perf_limit_status`

## Requirements
- R1: After reset the status register reads zero and `notify_o` is low.
- R2: When `limit_evt` is high, `auto_sel_en` is low and `lvl_delivered` is strictly below `lvl_desired` (with `lvl_desired` not above `lvl_guaranteed`), status bit 0 (requested-level shortfall) is set from the next cycle. Equality does not set it.
- R3: When `lvl_desired` exceeds `lvl_guaranteed`, the bit 0 comparison uses `lvl_guaranteed` as the threshold instead.
- R4: While `auto_sel_en` is high, status bit 0 is never set.
- R5: When `limit_evt` is high and `lvl_delivered` is strictly below `lvl_minimum`, status bit 1 (minimum shortfall) is set from the next cycle.
- R6: While `limit_evt` is low, neither status bit is set, whatever the levels are.
- R7: A set status bit stays set, even after its condition goes away, until software clears it.
- R8: A write with `reg_wr_en` high to address `STATUS_ADDR` (default 0) clears every status bit whose `reg_wdata` bit is 1. Bits written 0 are unchanged, and writes to other addresses have no effect.
- R9: If a bit's set condition and its clear occur in the same cycle, the bit stays set.
- R10: `reg_rdata` returns the status in bits [1:0] when `reg_rd_en` is high and `reg_addr` equals `STATUS_ADDR`. Bits [DATA_W-1:2] always read 0. At all other times `reg_rdata` is 0. Writes to bits 2 and above have no effect.
- R11: `notify_o` is high for exactly one cycle, one cycle after status bit 1 goes from 0 to 1. It stays low while bit 1 remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_delivered | input | LVL_W | Delivered performance level |
| lvl_desired | input | LVL_W | Requested performance level |
| lvl_minimum | input | LVL_W | Minimum acceptable level |
| lvl_guaranteed | input | LVL_W | Guaranteed level (slow-changing) |
| auto_sel_en | input | 1 | Autonomous level selection active |
| limit_evt | input | 1 | Limiting event in progress; qualifies comparisons |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data, ones clear status bits |
| reg_rdata | output | DATA_W | Read data (combinational) |
| notify_o | output | 1 | One-cycle host notify pulse |

## Verification
The bench targets the comparison boundaries. Delivered equal to the threshold must not set a bit, which a design using less-or-equal would get wrong. A delivered level between the guarantee and the request exposes a design that forgets the cap. It also holds the minimum shortfall for many cycles and counts notify pulses: an output that is level-driven rather than edge-driven would pulse repeatedly or stay high. Finally, it clears a bit in the very cycle its condition is present, then clears and re-limits. A design where clear beats set loses the event, and one that fails to re-arm never notifies a second time.

// File: rtl/perf_limit_pkg.sv
package perf_limit_pkg;
   localparam int STAT_W  = 2;
   localparam int DES_BIT = 0;
   localparam int MIN_BIT = 1;

   typedef struct packed {
      logic min_short;
      logic des_short;
   } shortfall_t;
endpackage

// File: rtl/perf_excursion_detect.sv
module perf_excursion_detect
   import perf_limit_pkg::*;
#(
   parameter int LVL_W = 8
) (
   input  logic [LVL_W-1:0] lvl_delivered,
   input  logic [LVL_W-1:0] lvl_desired,
   input  logic [LVL_W-1:0] lvl_minimum,
   input  logic [LVL_W-1:0] lvl_guaranteed,
   input  logic             auto_sel_en,
   input  logic             limit_evt,
   output shortfall_t       set_o
);
   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("perf_excursion_detect: LVL_W must be at least 1");
      end
   endgenerate

   logic [LVL_W-1:0] req_thresh;

   always_comb begin
      req_thresh      = (lvl_desired > lvl_guaranteed) ? lvl_guaranteed : lvl_desired;
      set_o.des_short = limit_evt && !auto_sel_en && (lvl_delivered < req_thresh);
      set_o.min_short = limit_evt && (lvl_delivered < lvl_minimum);
   end
endmodule

// File: rtl/perf_sticky_bit.sv
module perf_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= 1'b0;
      else if (set_i)  q_r <= 1'b1;
      else if (clr_i)  q_r <= 1'b0;
   end

   assign q_o = q_r;

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_r && !clr_i) |=> q_r);
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_r);
   // R8
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_r);
endmodule

// File: rtl/perf_rise_notify.sv
module perf_rise_notify (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_i,
   output logic pulse_o
);
   logic bit_d;
   logic pulse_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_d   <= 1'b0;
         pulse_r <= 1'b0;
      end else begin
         bit_d   <= bit_i;
         pulse_r <= bit_i && !bit_d;
      end
   end

   assign pulse_o = pulse_r;

   // R11
   notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
   // R11
   notify_follows_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_i) |=> pulse_o);
endmodule

// File: rtl/perf_limit_status.sv
module perf_limit_status
   import perf_limit_pkg::*;
#(
   parameter int LVL_W       = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int STATUS_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  lvl_delivered,
   input  logic [LVL_W-1:0]  lvl_desired,
   input  logic [LVL_W-1:0]  lvl_minimum,
   input  logic [LVL_W-1:0]  lvl_guaranteed,
   input  logic              auto_sel_en,
   input  logic              limit_evt,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              notify_o
);
   localparam int RSV_W = DATA_W - STAT_W;
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(STATUS_ADDR);

   generate
      if (DATA_W <= STAT_W) begin : g_bad_data
         $error("perf_limit_status: DATA_W must exceed the status width");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("perf_limit_status: ADDR_W must be at least 1");
      end
      if (STATUS_ADDR < 0 || STATUS_ADDR >= (1 << ADDR_W)) begin : g_bad_sel
         $error("perf_limit_status: STATUS_ADDR out of address range");
      end
   endgenerate

   shortfall_t        set_vec;
   logic [STAT_W-1:0] set_bits;
   logic [STAT_W-1:0] clr_bits;
   logic [STAT_W-1:0] status;
   logic              addr_hit;
   logic              unused_wdata;

   perf_excursion_detect #(.LVL_W(LVL_W)) detect_i (
      .lvl_delivered (lvl_delivered),
      .lvl_desired   (lvl_desired),
      .lvl_minimum   (lvl_minimum),
      .lvl_guaranteed(lvl_guaranteed),
      .auto_sel_en   (auto_sel_en),
      .limit_evt     (limit_evt),
      .set_o         (set_vec)
   );

   assign addr_hit     = (reg_addr == SEL_ADDR);
   assign set_bits     = set_vec;
   assign clr_bits     = (reg_wr_en && addr_hit) ? reg_wdata[STAT_W-1:0] : '0;
   assign unused_wdata = ^reg_wdata[DATA_W-1:STAT_W];

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_stat
         perf_sticky_bit bit_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_bits[b]),
            .clr_i(clr_bits[b]),
            .q_o  (status[b])
         );
      end
   endgenerate

   perf_rise_notify notify_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_i  (status[MIN_BIT]),
      .pulse_o(notify_o)
   );

   assign reg_rdata = (reg_rd_en && addr_hit) ? {{RSV_W{1'b0}}, status} : '0;

   // R10
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:STAT_W] == '0);
   // R5
   min_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_evt && (lvl_delivered < lvl_minimum)) |=> status[MIN_BIT]);
   // R4
   auto_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_sel_en && !status[DES_BIT]) |=> !status[DES_BIT]);
   // R6
   no_qualifier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!limit_evt && status == '0) |=> status == '0);
endmodule

// File: tb/perf_limit_status_tb_top.sv
`timescale 1ns/1ps
module perf_limit_status_tb_top;
   localparam int LVL_W = 8, DATA_W = 32, ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LVL_W-1:0]  lvl_delivered = '0, lvl_desired = '0, lvl_minimum = '0, lvl_guaranteed = '0;
   logic              auto_sel_en = 1'b0, limit_evt = 1'b0;
   logic              reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              notify_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   perf_limit_status #(.LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lvl_delivered(lvl_delivered), .lvl_desired(lvl_desired),
      .lvl_minimum(lvl_minimum), .lvl_guaranteed(lvl_guaranteed),
      .auto_sel_en(auto_sel_en), .limit_evt(limit_evt),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .notify_o(notify_o)
   );

   task automatic check(string req, longint got, longint exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic read_status(output logic [DATA_W-1:0] val);
      reg_rd_en = 1'b1; reg_addr = '0;
      #1 val = reg_rdata;
      reg_rd_en = 1'b0;
   endtask

   // one write strobe across one rising edge, inputs changed at negedge
   task automatic write_reg(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic set_levels(int del, int des, int mn, int gu);
      lvl_delivered = LVL_W'(del); lvl_desired = LVL_W'(des);
      lvl_minimum = LVL_W'(mn); lvl_guaranteed = LVL_W'(gu);
   endtask

   task automatic clear_all();
      limit_evt = 1'b0; auto_sel_en = 1'b0;
      write_reg('0, 32'h3);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DATA_W-1:0] v;
      read_status(v);
      check("R1 status after reset", v, 0);
      check("R1 notify after reset", notify_o, 0);
      reg_rd_en = 1'b0; reg_addr = '0;
      #1 check("R10 rdata idle is zero", reg_rdata, 0);
   endtask

   task automatic t_desired();
      logic [DATA_W-1:0] v;
      set_levels(100, 100, 10, 200); limit_evt = 1'b1;
      @(negedge clk);
      read_status(v); check("R2 equality does not set", v, 0);
      lvl_delivered = 8'd99;
      @(negedge clk); limit_evt = 1'b0;
      read_status(v); check("R2 shortfall sets bit0", v, 1);
      set_levels(200, 100, 10, 200); @(negedge clk); @(negedge clk);
      read_status(v); check("R7 bit0 sticks after condition ends", v, 1);
      write_reg(4'h3, 32'h3);
      read_status(v); check("R8 other address no effect", v, 1);
      write_reg('0, 32'h2);
      read_status(v); check("R8 zero bit leaves bit0", v, 1);
      write_reg('0, 32'h1);
      read_status(v); check("R8 write-one clears bit0", v, 0);
   endtask

   task automatic t_cap();
      logic [DATA_W-1:0] v;
      set_levels(130, 150, 10, 120); limit_evt = 1'b1;
      @(negedge clk);
      read_status(v); check("R3 above guarantee not a shortfall", v, 0);
      lvl_delivered = 8'd119;
      @(negedge clk); limit_evt = 1'b0;
      read_status(v); check("R3 below guarantee sets bit0", v, 1);
      clear_all();
   endtask

   task automatic t_auto();
      logic [DATA_W-1:0] v;
      set_levels(10, 100, 5, 200); auto_sel_en = 1'b1; limit_evt = 1'b1;
      repeat (3) @(negedge clk);
      limit_evt = 1'b0; auto_sel_en = 1'b0;
      read_status(v); check("R4 autonomous blocks bit0", v, 0);
   endtask

   task automatic t_no_qual();
      logic [DATA_W-1:0] v;
      set_levels(1, 200, 150, 200); limit_evt = 1'b0;
      repeat (3) @(negedge clk);
      read_status(v); check("R6 no qualifier no set", v, 0);
      check("R6 no notify", notify_o, 0);
   endtask

   task automatic t_minimum_notify();
      logic [DATA_W-1:0] v;
      int pulses = 0;
      set_levels(40, 40, 60, 200); limit_evt = 1'b1;
      @(negedge clk);
      read_status(v); check("R5 bit1 set, bit0 not", v, 2);
      check("R11 notify not yet", notify_o, 0);
      @(negedge clk);
      check("R11 notify one cycle after bit1", notify_o, 1);
      @(negedge clk);
      check("R11 notify single cycle", notify_o, 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (notify_o) pulses++;
      end
      check("R11 no repeat while held", pulses, 0);
      // clear in the same cycle as a live set
      write_reg('0, 32'h2);
      read_status(v); check("R9 set wins over clear", v, 2);
      pulses = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (notify_o) pulses++;
      end
      check("R9 no notify after survived clear", pulses, 0);
      limit_evt = 1'b0;
      write_reg('0, 32'h2);
      read_status(v); check("R8 bit1 cleared", v, 0);
      limit_evt = 1'b1;
      @(negedge clk); limit_evt = 1'b0;
      @(negedge clk);
      check("R11 re-armed notify fires", notify_o, 1);
      clear_all();
   endtask

   task automatic t_reserved();
      logic [DATA_W-1:0] v;
      set_levels(1, 100, 50, 200); limit_evt = 1'b1;
      @(negedge clk); limit_evt = 1'b0;
      write_reg('0, 32'hFFFF_FFFC);
      read_status(v);
      check("R10 reserved write no effect", v, 3);
      check("R10 reserved bits read zero", v[DATA_W-1:2], 0);
      clear_all();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_desired();
      t_cap();
      t_auto();
      t_no_qual();
      t_minimum_notify();
      t_reserved();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule